// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind the flag and bit-unstuffing logic of a bit-synchronous HDLC receiver. It looks at the leading address byte, or the two leading address bytes, of every received frame. From them it decides whether the frame is meant for this station. Only frames that pass are written into the receive buffer. A rejected frame produces no buffer writes at all.

A one-cycle `frame_start` pulse opens a frame and a one-cycle `frame_end` pulse closes it. Bytes arrive on `rx_byte` qualified by `rx_valid`, and a byte may share its cycle with either pulse. The block holds the two most recent bytes of the open frame until the verdict is known. The write stream on `buf_wr`/`buf_data` therefore trails the input by two bytes. The two held bytes drain in the two cycles after the frame end.

A two-bit mode and two address bytes are captured at the frame start. The verdict is shown on `verdict_valid`/`verdict_accept` as soon as the address field settles it.

Top module: `hdlc_addr_filter`

## Requirements
- R1: With `match_mode` = 00 (no check), every frame passes: the verdict reads valid and accepting from the cycle after the frame start, including frames with no bytes.
- R2: With `match_mode` = 01, a frame passes only if its first byte equals `match_addr1` or is all ones (FFh). The verdict is valid in the cycle after that first byte.
- R3: With `match_mode` = 10, a frame passes only if its second byte equals `match_addr2` or is FFh. The verdict stays not-valid after the first byte and becomes valid after the second.
- R4: With `match_mode` = 11, a frame passes if any of these holds: byte one equals `match_addr1` and byte two equals `match_addr2`; both bytes are FFh; or byte one is FFh and byte two equals `match_addr2`. Any other pair is rejected.
- R5: A frame that ends before its mode has seen enough address bytes is rejected at its end.
- R6: Every byte of a passing frame is written to the buffer exactly once and in arrival order. The last two are written in the two cycles after the frame end.
- R7: A rejected frame causes no buffer write.
- R8: Mode and both address bytes are sampled at the frame start. Changing them while a frame is open has no effect on that frame.
- R9: Bytes presented while no frame is open are ignored. They are not written and they leave the verdict unchanged.
- R10: While `rst` is high, `buf_wr` and `verdict_valid` are low in the following cycle.
- R11: A byte given in the same cycle as `frame_start` is the frame's first byte. A byte given in the same cycle as `frame_end` is the frame's last byte.
- R12: Once valid, the verdict holds until the next frame start. A frame start in any mode other than 00, with no byte, clears it to not-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse opening a frame |
| rx_valid | input | 1 | `rx_byte` holds a received byte |
| rx_byte | input | BYTE_W | Received byte |
| frame_end | input | 1 | One-cycle pulse closing the open frame |
| match_mode | input | 2 | Filter mode, sampled at frame start |
| match_addr1 | input | BYTE_W | Expected first address byte |
| match_addr2 | input | BYTE_W | Expected second address byte |
| verdict_valid | output | 1 | Verdict for the current or last frame is settled |
| verdict_accept | output | 1 | Settled verdict is pass |
| buf_wr | output | 1 | Write strobe into the receive buffer |
| buf_data | output | BYTE_W | Byte to write |

## Verification
The sharp case is a frame end arriving in the same cycle as a byte. That byte may be the deciding address byte, which turns a short-frame reject into a pass or a mismatch. It may also be the byte that pushes the oldest held byte out while the rest of the hold line moves into the drain. The bench provokes this on purpose, together with a first byte that shares its cycle with the frame start. For each frame it checks the final verdict against a model of the four modes and checks that the collected buffer writes equal the frame bytes, or are empty.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

    localparam int AF_ADDR_BYTES = 2;

    typedef enum logic [1:0] {
        AF_MODE_ANY    = 2'd0,
        AF_MODE_FIRST  = 2'd1,
        AF_MODE_SECOND = 2'd2,
        AF_MODE_BOTH   = 2'd3
    } af_mode_e;

    typedef enum logic [1:0] {
        AF_WAIT = 2'd0,
        AF_PASS = 2'd1,
        AF_DROP = 2'd2
    } af_verdict_e;

    typedef struct packed {
        logic        open;
        af_verdict_e verdict;
        logic [1:0]  seen;
        logic        lead_hit;
        logic        lead_bcast;
    } af_track_t;

    function automatic af_verdict_e af_start_verdict(input af_mode_e m);
        return (m == AF_MODE_ANY) ? AF_PASS : AF_WAIT;
    endfunction

endpackage

// File: rtl/af_decider.sv
module af_decider
    import hdlc_af_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              eof_i,
    input  af_mode_e          mode_i,
    input  logic [BYTE_W-1:0] addr1_i,
    input  logic [BYTE_W-1:0] addr2_i,
    output af_verdict_e       verdict_q_o,
    output af_verdict_e       verdict_nx_o,
    output logic              take_o,
    output logic              close_o,
    output logic              open_o
);

    localparam logic [BYTE_W-1:0] ALL_ONES = {BYTE_W{1'b1}};

    af_track_t         track_q, track_nx;
    af_mode_e          mode_q, mode_eff;
    logic [BYTE_W-1:0] a1_q, a2_q, a1_eff, a2_eff;
    logic              take, close;

    always_comb begin
        mode_eff = sof_i ? mode_i  : mode_q;
        a1_eff   = sof_i ? addr1_i : a1_q;
        a2_eff   = sof_i ? addr2_i : a2_q;
        track_nx = track_q;
        if (sof_i) begin
            track_nx.open       = 1'b1;
            track_nx.verdict    = af_start_verdict(mode_i);
            track_nx.seen       = 2'd0;
            track_nx.lead_hit   = 1'b0;
            track_nx.lead_bcast = 1'b0;
        end
        take = byte_vld_i && track_nx.open;
        if (take) begin
            if (track_nx.seen == 2'd0) begin
                track_nx.lead_hit   = (byte_i == a1_eff);
                track_nx.lead_bcast = (byte_i == ALL_ONES);
            end
            if (track_nx.verdict == AF_WAIT) begin
                case (mode_eff)
                    AF_MODE_FIRST: begin
                        if (track_nx.seen == 2'd0)
                            track_nx.verdict = (track_nx.lead_hit || track_nx.lead_bcast)
                                               ? AF_PASS : AF_DROP;
                    end
                    AF_MODE_SECOND: begin
                        if (track_nx.seen == 2'd1)
                            track_nx.verdict = (byte_i == a2_eff || byte_i == ALL_ONES)
                                               ? AF_PASS : AF_DROP;
                    end
                    AF_MODE_BOTH: begin
                        if (track_nx.seen == 2'd1)
                            track_nx.verdict =
                                ((track_nx.lead_hit && byte_i == a2_eff) ||
                                 (track_nx.lead_bcast &&
                                  (byte_i == ALL_ONES || byte_i == a2_eff)))
                                ? AF_PASS : AF_DROP;
                    end
                    default: ;
                endcase
            end
            if (track_nx.seen != 2'd2)
                track_nx.seen = track_nx.seen + 2'd1;
        end
        close = eof_i && track_nx.open;
        if (close) begin
            track_nx.open = 1'b0;
            if (track_nx.verdict == AF_WAIT)
                track_nx.verdict = AF_DROP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            track_q <= '0;
            mode_q  <= AF_MODE_ANY;
            a1_q    <= '0;
            a2_q    <= '0;
        end else begin
            track_q <= track_nx;
            if (sof_i) begin
                mode_q <= mode_i;
                a1_q   <= addr1_i;
                a2_q   <= addr2_i;
            end
        end
    end

    assign verdict_q_o  = track_q.verdict;
    assign verdict_nx_o = track_nx.verdict;
    assign take_o       = take;
    assign close_o      = close;
    assign open_o       = track_q.open;

endmodule

// File: rtl/af_gate.sv
module af_gate
    import hdlc_af_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int HOLD   = AF_ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof_i,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              close_i,
    input  af_verdict_e       verdict_nx_i,
    output logic              wr_o,
    output logic [BYTE_W-1:0] data_o
);

    logic [HOLD-1:0]             hold_v_q, hv, drain_v_q, dv;
    logic [HOLD-1:0][BYTE_W-1:0] hold_d_q, hd, drain_d_q, dd;
    logic                        drain_pass_q, dpass;
    logic                        pop, placed, d_emit;
    logic [BYTE_W-1:0]           pop_byte, d_byte;
    logic                        wr_nx;
    logic [BYTE_W-1:0]           wd_nx;
    logic                        wr_q;
    logic [BYTE_W-1:0]           wd_q;

    always_comb begin
        hv     = sof_i ? '0 : hold_v_q;
        hd     = hold_d_q;
        d_emit = drain_v_q[0] && drain_pass_q;
        d_byte = drain_d_q[0];
        dpass  = drain_pass_q;
        dv     = {1'b0, drain_v_q[HOLD-1:1]};
        for (int i = 0; i < HOLD - 1; i++)
            dd[i] = drain_d_q[i+1];
        dd[HOLD-1] = drain_d_q[HOLD-1];

        pop      = 1'b0;
        pop_byte = '0;
        placed   = 1'b0;
        if (take_i) begin
            if (hv[HOLD-1]) begin
                pop      = 1'b1;
                pop_byte = hd[0];
                for (int i = 0; i < HOLD - 1; i++)
                    hd[i] = hd[i+1];
                hd[HOLD-1] = byte_i;
            end else begin
                for (int i = 0; i < HOLD; i++) begin
                    if (!hv[i] && !placed) begin
                        hv[i]  = 1'b1;
                        hd[i]  = byte_i;
                        placed = 1'b1;
                    end
                end
            end
        end

        if (close_i) begin
            dv    = hv;
            dd    = hd;
            dpass = (verdict_nx_i == AF_PASS);
            hv    = '0;
        end

        wr_nx = (pop && verdict_nx_i == AF_PASS) || d_emit;
        wd_nx = pop ? pop_byte : d_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v_q     <= '0;
            hold_d_q     <= '0;
            drain_v_q    <= '0;
            drain_d_q    <= '0;
            drain_pass_q <= 1'b0;
            wr_q         <= 1'b0;
            wd_q         <= '0;
        end else begin
            hold_v_q     <= hv;
            hold_d_q     <= hd;
            drain_v_q    <= dv;
            drain_d_q    <= dd;
            drain_pass_q <= dpass;
            wr_q         <= wr_nx;
            wd_q         <= wd_nx;
        end
    end

    assign wr_o   = wr_q;
    assign data_o = wd_q;

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hdlc_af_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              frame_end,
    input  logic [1:0]        match_mode,
    input  logic [BYTE_W-1:0] match_addr1,
    input  logic [BYTE_W-1:0] match_addr2,
    output logic              verdict_valid,
    output logic              verdict_accept,
    output logic              buf_wr,
    output logic [BYTE_W-1:0] buf_data
);

    af_verdict_e verdict_q, verdict_nx;
    logic        take, close, frame_open;

    af_decider #(.BYTE_W(BYTE_W)) u_decider (
        .clk          (clk),
        .rst          (rst),
        .sof_i        (frame_start),
        .byte_vld_i   (rx_valid),
        .byte_i       (rx_byte),
        .eof_i        (frame_end),
        .mode_i       (af_mode_e'(match_mode)),
        .addr1_i      (match_addr1),
        .addr2_i      (match_addr2),
        .verdict_q_o  (verdict_q),
        .verdict_nx_o (verdict_nx),
        .take_o       (take),
        .close_o      (close),
        .open_o       (frame_open)
    );

    af_gate #(.BYTE_W(BYTE_W), .HOLD(AF_ADDR_BYTES)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .sof_i        (frame_start),
        .take_i       (take),
        .byte_i       (rx_byte),
        .close_i      (close),
        .verdict_nx_i (verdict_nx),
        .wr_o         (buf_wr),
        .data_o       (buf_data)
    );

    assign verdict_valid  = (verdict_q != AF_WAIT);
    assign verdict_accept = (verdict_q == AF_PASS);

endmodule

// File: rtl/af_checker.sv
module af_checker (
    input logic       clk,
    input logic       rst,
    input logic       frame_start,
    input logic       rx_valid,
    input logic       frame_end,
    input logic [1:0] match_mode,
    input logic       verdict_valid,
    input logic       verdict_accept,
    input logic       buf_wr,
    input logic       frame_open
);

    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!buf_wr && !verdict_valid));

    p_any_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (frame_start && match_mode == 2'b00) |=> (verdict_valid && verdict_accept));

    p_first_fast_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_start && rx_valid && match_mode == 2'b01) |=> verdict_valid);

    p_second_waits_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_start && rx_valid && !frame_end && match_mode == 2'b10) |=> !verdict_valid);

    p_short_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_open && frame_end && !rx_valid && !frame_start && !verdict_valid)
        |=> (verdict_valid && !verdict_accept));

    p_drop_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && !verdict_accept && !frame_start) |=> !buf_wr);

    p_closed_stays_r9: assert property (@(posedge clk) disable iff (rst)
        (!frame_open && !frame_start) |=> !frame_open);

    p_verdict_holds_r12: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && !frame_start) |=> (verdict_valid && $stable(verdict_accept)));

endmodule

bind hdlc_addr_filter af_checker u_af_checker (
    .clk            (clk),
    .rst            (rst),
    .frame_start    (frame_start),
    .rx_valid       (rx_valid),
    .frame_end      (frame_end),
    .match_mode     (match_mode),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept),
    .buf_wr         (buf_wr),
    .frame_open     (frame_open)
);

// File: tb/hdlc_addr_filter_tb.sv
module hdlc_addr_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ADR1 = 8'h3C;
    localparam logic [7:0] ADR2 = 8'hA5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       frame_end = 1'b0;
    logic [1:0] match_mode = '0;
    logic [7:0] match_addr1 = '0;
    logic [7:0] match_addr2 = '0;
    logic       verdict_valid, verdict_accept, buf_wr;
    logic [7:0] buf_data;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] fb [0:7];
    logic [7:0] got [$];
    logic v_after1;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_addr_filter #(.BYTE_W(8)) dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .frame_end(frame_end), .match_mode(match_mode),
        .match_addr1(match_addr1), .match_addr2(match_addr2),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept),
        .buf_wr(buf_wr), .buf_data(buf_data)
    );

    always @(negedge clk) if (!rst && buf_wr) got.push_back(buf_data);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        frame_start = 1'b0; rx_valid = 1'b0; frame_end = 1'b0;
    endtask

    function automatic bit exp_accept(input logic [1:0] m, input logic [7:0] a1,
                                      input logic [7:0] a2, input int len);
        case (m)
            2'd0: return 1'b1;
            2'd1: return len >= 1 && (fb[0] == a1 || fb[0] == 8'hFF);
            2'd2: return len >= 2 && (fb[1] == a2 || fb[1] == 8'hFF);
            default: return len >= 2 && ((fb[0] == a1 && fb[1] == a2) ||
                                         (fb[0] == 8'hFF && (fb[1] == 8'hFF || fb[1] == a2)));
        endcase
    endfunction

    task automatic run_frame(input logic [1:0] m, input logic [7:0] a1, input logic [7:0] a2,
                             input int len, input bit join_start, input bit join_end,
                             input bit scramble, input bit rand_gap, input string req);
        int  idx = 0;
        bit  acc;
        got.delete();
        v_after1 = 1'b0;
        match_mode = m; match_addr1 = a1; match_addr2 = a2;
        frame_start = 1'b1;
        if (join_start && len > 0) begin
            rx_valid = 1'b1; rx_byte = fb[0]; idx = 1;
            if (len == 1 && join_end) frame_end = 1'b1;
        end
        tick();
        if (idx == 1) v_after1 = verdict_valid;
        if (scramble) begin
            match_mode = 2'($urandom); match_addr1 = 8'($urandom); match_addr2 = 8'($urandom);
        end
        while (idx < len) begin
            if (rand_gap) repeat ($urandom % 3) tick();
            rx_valid = 1'b1; rx_byte = fb[idx];
            if (idx == len - 1 && join_end) frame_end = 1'b1;
            tick();
            idx++;
            if (idx == 1) v_after1 = verdict_valid;
        end
        if (!(join_end && len > 0)) begin
            frame_end = 1'b1;
            tick();
        end
        repeat (3) tick();
        acc = exp_accept(m, a1, a2, len);
        chk(verdict_valid == 1'b1, req, "verdict valid after end", verdict_valid, 1);
        chk(verdict_accept == acc, req, "verdict accept", verdict_accept, acc);
        if (acc) begin
            chk(got.size() == len, "R6", "write count", got.size(), len);
            for (int i = 0; i < len && i < got.size(); i++)
                chk(got[i] == fb[i], "R6", "write order/data", got[i], fb[i]);
        end else begin
            chk(got.size() == 0, "R7", "writes from rejected frame", got.size(), 0);
        end
    endtask

    task automatic set2(input logic [7:0] b0, input logic [7:0] b1);
        fb[0] = b0; fb[1] = b1;
        for (int i = 2; i < 8; i++) fb[i] = 8'(8'h10 + i);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit keep;
        void'($urandom(32'd4321));
        repeat (3) tick();
        chk(verdict_valid == 0, "R10", "verdict_valid in reset", verdict_valid, 0);
        chk(buf_wr == 0, "R10", "buf_wr in reset", buf_wr, 0);
        rst = 1'b0;
        tick();

        // R1 no check, including empty frame
        set2(8'h01, 8'h02);
        run_frame(2'd0, ADR1, ADR2, 5, 1, 1, 0, 0, "R1");
        run_frame(2'd0, ADR1, ADR2, 0, 0, 0, 0, 0, "R1");
        // R2 first byte: hit, broadcast, miss; early verdict
        set2(ADR1, 8'h55);
        run_frame(2'd1, ADR1, ADR2, 4, 1, 0, 0, 0, "R2");
        chk(v_after1 == 1, "R2", "verdict after first byte", v_after1, 1);
        set2(8'hFF, 8'h55);
        run_frame(2'd1, ADR1, ADR2, 3, 0, 1, 0, 0, "R2");
        set2(8'h3D, 8'h55);
        run_frame(2'd1, ADR1, ADR2, 4, 1, 1, 0, 0, "R2");
        // R3 second byte
        set2(8'h00, ADR2);
        run_frame(2'd2, ADR1, ADR2, 4, 1, 0, 0, 0, "R3");
        chk(v_after1 == 0, "R3", "no verdict after first byte", v_after1, 0);
        set2(8'h00, 8'hFF);
        run_frame(2'd2, ADR1, ADR2, 3, 0, 0, 0, 0, "R3");
        set2(ADR2, ADR1);
        run_frame(2'd2, ADR1, ADR2, 3, 1, 0, 0, 0, "R3");
        // R4 dual: exact, global, group, and three rejects; R11 deciding byte with end
        set2(ADR1, ADR2);  run_frame(2'd3, ADR1, ADR2, 2, 1, 1, 0, 0, "R4");
        set2(8'hFF, 8'hFF); run_frame(2'd3, ADR1, ADR2, 3, 0, 0, 0, 0, "R4");
        set2(8'hFF, ADR2); run_frame(2'd3, ADR1, ADR2, 2, 0, 1, 0, 0, "R11");
        set2(ADR1, 8'hFF); run_frame(2'd3, ADR1, ADR2, 4, 0, 0, 0, 0, "R4");
        set2(ADR1, 8'h00); run_frame(2'd3, ADR1, ADR2, 4, 1, 0, 0, 0, "R4");
        set2(8'h00, ADR2); run_frame(2'd3, ADR1, ADR2, 4, 0, 0, 0, 0, "R4");
        // R5 short frames
        set2(ADR1, ADR2);
        run_frame(2'd3, ADR1, ADR2, 1, 1, 1, 0, 0, "R5");
        run_frame(2'd2, ADR1, ADR2, 1, 0, 0, 0, 0, "R5");
        run_frame(2'd1, ADR1, ADR2, 0, 0, 0, 0, 0, "R5");
        // R8 config scrambled during frame
        set2(ADR1, ADR2);
        run_frame(2'd3, ADR1, ADR2, 6, 1, 0, 1, 0, "R8");
        set2(8'h77, ADR2);
        run_frame(2'd1, ADR1, ADR2, 5, 0, 1, 1, 0, "R8");
        // R9 bytes outside a frame, after a passing frame
        set2(8'h00, 8'h00);
        run_frame(2'd0, ADR1, ADR2, 3, 0, 0, 0, 0, "R9");
        got.delete();
        keep = verdict_accept;
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1; rx_byte = 8'(8'hC0 + i); tick();
        end
        repeat (3) tick();
        chk(got.size() == 0, "R9", "writes outside frame", got.size(), 0);
        chk(verdict_valid == 1 && verdict_accept == keep, "R9", "verdict moved",
            verdict_accept, keep);
        // R12 start clears verdict
        match_mode = 2'd3; frame_start = 1'b1; tick();
        chk(verdict_valid == 0, "R12", "verdict cleared by start", verdict_valid, 0);
        frame_end = 1'b1; tick(); repeat (3) tick();

        // random mix
        for (int f = 0; f < 150; f++) begin
            logic [1:0] m  = 2'($urandom);
            logic [7:0] a1 = ($urandom % 8 == 0) ? 8'hFF : 8'($urandom);
            logic [7:0] a2 = ($urandom % 8 == 0) ? 8'hFF : 8'($urandom);
            int len = $urandom % 8;
            for (int i = 0; i < 8; i++) begin
                case ($urandom % 4)
                    0: fb[i] = a1;
                    1: fb[i] = a2;
                    2: fb[i] = 8'hFF;
                    default: fb[i] = 8'($urandom);
                endcase
            end
            run_frame(m, a1, a2, len, 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, "R11");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule